// File: doc/BRIEF.md
# Page-Translated Single-Channel DMA Engine

This block moves a stream of bytes between one I/O device and system memory on a single channel. Software programs a logical start address and a byte budget. The engine treats the address as logical. For every 4 KB logical page it reads a translation entry from a table in memory. It then forms the physical address from the page bits of that entry and the offset bits of the logical address.

A transfer begins when the device raises a request that states its direction. The engine accepts the request only if the channel is running and the direction matches the direction software programmed. It then fetches translation entries and moves data one byte per memory beat. It stops when it has used up the programmed byte budget or the device's own byte count, whichever comes first. At that point it clears the count register and raises a one-cycle completion pulse.

Top module: `pt_dma`

## Requirements
- R1: After reset, every register reads as zero, and `mem_valid_o`, `dev_rvalid_o`, `dev_wready_o`, `done_o` and `dev_reject_o` are low.
- R2: Registers sit at byte offsets 0x00 (mode), 0x08 (enable), 0x10 (count), 0x18 (logical start address), 0x20 (table base) and 0x28 (table limit). Each reads back the last 32-bit value written to it. Any other offset ignores writes and reads as zero. In the enable register, bit 0 is RUN and bit 1 is WRITE.
- R3: The translation entry for logical address L is the 32-bit word at table_base + (L >> 12) * 8. It is fetched as four one-byte memory reads at that address +0, +1, +2 and +3, in that order.
- R4: The physical address of a data beat is the entry word with its low 12 bits forced to zero, plus the low 12 bits of the logical address.
- R5: With `big_endian_i` = 1, the byte read at entry offset +0 is the most significant byte of the entry word. With `big_endian_i` = 0, it is the least significant byte.
- R6: With WRITE = 1, data flows from memory to the device. Each byte is read from memory at its physical address and then offered on `dev_rdata_o` under `dev_rvalid_o`, until `dev_rready_i` accepts it.
- R7: With WRITE = 0, data flows from the device to memory. Each byte accepted on `dev_wdata_i` is written to memory at its physical address.
- R8: A request whose `dev_to_mem_i` equals the WRITE bit raises `dev_reject_o` in the same cycle. It causes no memory beat and no completion pulse, and the count register keeps its value.
- R9: A request made while RUN is 0 is ignored: no reject, no memory beat and no completion pulse.
- R10: A transfer moves min(count, `dev_len_i`) bytes, at consecutive logical addresses from the start address. It then pulses `done_o` for exactly one cycle and clears the count register to zero. A zero count completes with no memory beat.
- R11: Each transfer fetches an entry for its first byte. After that, it fetches an entry only when the logical address reaches a new 4 KB page. Bytes within the same page reuse the cached entry.
- R12: The memory interface carries one byte per beat and completes a beat when `mem_valid_o` and `mem_ready_i` are both high. While a beat is waiting for ready, its valid, address, direction and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| big_endian_i | input | 1 | Byte order used to assemble translation entries |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for the offset on reg_addr_i |
| dev_req_i | input | 1 | Device transfer request, one cycle |
| dev_to_mem_i | input | 1 | Requested direction: 1 = device to memory |
| dev_len_i | input | 16 | Bytes the device can move in this request |
| dev_reject_o | output | 1 | Request refused because of a direction mismatch |
| done_o | output | 1 | One-cycle pulse when a transfer ends |
| dev_wdata_i | input | 8 | Byte from the device |
| dev_wvalid_i | input | 1 | Device byte valid |
| dev_wready_o | output | 1 | Engine accepts a device byte |
| dev_rdata_o | output | 8 | Byte to the device |
| dev_rvalid_o | output | 1 | Byte to the device is valid |
| dev_rready_i | input | 1 | Device accepts the byte |
| mem_valid_o | output | 1 | Memory beat request |
| mem_we_o | output | 1 | Memory beat is a write |
| mem_addr_o | output | 32 | Physical byte address of the beat |
| mem_wdata_o | output | 8 | Write byte |
| mem_ready_i | input | 1 | Memory completes the beat |
| mem_rdata_i | input | 8 | Read byte, valid when the beat completes |

## Verification
A memory-to-device transfer that starts four bytes below a page boundary, with the device offering more bytes than the count, shows whether entries are refetched only at the page crossing and whether the count sets the stopping point. A device-to-memory transfer across a page, with a device length shorter than the count, checks the write path and the device-length limit. A little-endian run with entry words that carry nonzero low bits separates the two byte orders and checks that the low 12 bits are masked. A wrong-direction request, a request with RUN clear and a zero-count transfer each have to leave the memory interface silent, and they differ only in whether a reject or a completion pulse appears.

// File: rtl/pt_dma_pkg.sv
package pt_dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_FETCH, ST_RD, ST_PUSH, ST_GET, ST_WR, ST_DONE
  } dma_st_e;

  localparam logic [5:0] OFF_MODE  = 6'h00;
  localparam logic [5:0] OFF_EN    = 6'h08;
  localparam logic [5:0] OFF_CNT   = 6'h10;
  localparam logic [5:0] OFF_ADDR  = 6'h18;
  localparam logic [5:0] OFF_TBASE = 6'h20;
  localparam logic [5:0] OFF_TLIM  = 6'h28;

  localparam int EN_RUN_BIT   = 0;
  localparam int EN_WRITE_BIT = 1;
endpackage

// File: rtl/pt_dma_regs.sv
module pt_dma_regs
  import pt_dma_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [5:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          clr_count_i,
  output logic          run_o,
  output logic          write_o,
  output logic [DW-1:0] count_o,
  output logic [DW-1:0] start_o,
  output logic [DW-1:0] tbase_o
);
  logic [DW-1:0] mode_q, en_q, cnt_q, addr_q, tbase_q, tlim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      en_q    <= '0;
      cnt_q   <= '0;
      addr_q  <= '0;
      tbase_q <= '0;
      tlim_q  <= '0;
    end else begin
      if (wr_i) begin
        unique case (addr_i)
          OFF_MODE:  mode_q  <= wdata_i;
          OFF_EN:    en_q    <= wdata_i;
          OFF_CNT:   cnt_q   <= wdata_i;
          OFF_ADDR:  addr_q  <= wdata_i;
          OFF_TBASE: tbase_q <= wdata_i;
          OFF_TLIM:  tlim_q  <= wdata_i;
          default: ;
        endcase
      end
      // completion wins over a same-cycle write
      if (clr_count_i) cnt_q <= '0;
    end
  end

  always_comb begin
    unique case (addr_i)
      OFF_MODE:  rdata_o = mode_q;
      OFF_EN:    rdata_o = en_q;
      OFF_CNT:   rdata_o = cnt_q;
      OFF_ADDR:  rdata_o = addr_q;
      OFF_TBASE: rdata_o = tbase_q;
      OFF_TLIM:  rdata_o = tlim_q;
      default:   rdata_o = '0;
    endcase
  end

  assign run_o   = en_q[EN_RUN_BIT];
  assign write_o = en_q[EN_WRITE_BIT];
  assign count_o = cnt_q;
  assign start_o = addr_q;
  assign tbase_o = tbase_q;

  // R10
  count_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_count_i |=> cnt_q == '0);
endmodule

// File: rtl/pt_dma_xlate.sv
module pt_dma_xlate #(
  parameter int AW        = 32,
  parameter int PAGE_BITS = 12,
  localparam int WB       = AW / 8,
  localparam int IDX_W    = $clog2(WB)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inval_i,
  input  logic             cap_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       byte_i,
  input  logic             big_endian_i,
  input  logic [AW-1:0]    laddr_i,
  output logic             hit_o,
  output logic [AW-1:0]    paddr_o
);
  localparam int TAG_W = AW - PAGE_BITS;

  logic [7:0]       ent_q [WB];
  logic [TAG_W-1:0] tag_q;
  logic             vld_q;
  logic [AW-1:0]    word;
  logic             last;

  assign last = cap_i && (idx_i == IDX_W'(WB - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WB; i++) ent_q[i] <= '0;
      tag_q <= '0;
      vld_q <= 1'b0;
    end else begin
      if (cap_i) ent_q[idx_i] <= byte_i;
      if (inval_i) vld_q <= 1'b0;
      else if (last) begin
        vld_q <= 1'b1;
        tag_q <= laddr_i[AW-1:PAGE_BITS];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < WB; i++)
      word[8*i +: 8] = big_endian_i ? ent_q[WB-1-i] : ent_q[i];
  end

  assign hit_o   = vld_q && (tag_q == laddr_i[AW-1:PAGE_BITS]);
  assign paddr_o = {word[AW-1:PAGE_BITS], laddr_i[PAGE_BITS-1:0]};

  // R11
  commit_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last && !inval_i |=> hit_o);
endmodule

// File: rtl/pt_dma_ctrl.sv
module pt_dma_ctrl
  import pt_dma_pkg::*;
#(
  parameter int AW          = 32,
  parameter int LW          = 16,
  parameter int PAGE_BITS   = 12,
  parameter int ENTRY_BYTES = 8,
  localparam int WB         = AW / 8,
  localparam int IDX_W      = $clog2(WB),
  localparam int ENT_SH     = $clog2(ENTRY_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             write_i,
  input  logic [AW-1:0]    count_i,
  input  logic [AW-1:0]    start_i,
  input  logic [AW-1:0]    tbase_i,
  input  logic             dev_req_i,
  input  logic             dev_to_mem_i,
  input  logic [LW-1:0]    dev_len_i,
  output logic             dev_reject_o,
  output logic             done_o,
  input  logic [7:0]       dev_wdata_i,
  input  logic             dev_wvalid_i,
  output logic             dev_wready_o,
  output logic [7:0]       dev_rdata_o,
  output logic             dev_rvalid_o,
  input  logic             dev_rready_i,
  output logic             mem_valid_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [7:0]       mem_wdata_o,
  input  logic             mem_ready_i,
  input  logic [7:0]       mem_rdata_i,
  output logic             inval_o,
  output logic             cap_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [AW-1:0]    cur_o,
  input  logic             hit_i,
  input  logic [AW-1:0]    paddr_i
);
  dma_st_e st_q, st_d;
  logic [AW-1:0]    cur_q, lim_q, moved_q, tbl_addr;
  logic [LW-1:0]    rem_q;
  logic             dir_rd_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       buf_q;
  logic             req_ok, start, advance, idx_last;

  assign req_ok       = (st_q == ST_IDLE) && dev_req_i && run_i;
  assign start        = req_ok && (dev_to_mem_i != write_i);
  assign dev_reject_o = req_ok && (dev_to_mem_i == write_i);
  assign idx_last     = idx_q == IDX_W'(WB - 1);

  assign tbl_addr    = tbase_i + ((cur_q >> PAGE_BITS) << ENT_SH) + AW'(idx_q);
  assign mem_valid_o = st_q inside {ST_FETCH, ST_RD, ST_WR};
  assign mem_we_o    = st_q == ST_WR;
  assign mem_addr_o  = (st_q == ST_FETCH) ? tbl_addr : paddr_i;
  assign mem_wdata_o = buf_q;
  assign dev_rvalid_o = st_q == ST_PUSH;
  assign dev_rdata_o  = buf_q;
  assign dev_wready_o = st_q == ST_GET;
  assign done_o       = st_q == ST_DONE;
  assign advance = (st_q == ST_PUSH && dev_rready_i) || (st_q == ST_WR && mem_ready_i);
  assign inval_o = start;
  assign cap_o   = st_q == ST_FETCH && mem_ready_i;
  assign idx_o   = idx_q;
  assign cur_o   = cur_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start) st_d = ST_CHECK;
      ST_CHECK: begin
        if (moved_q >= lim_q || rem_q == '0) st_d = ST_DONE;
        else if (!hit_i)                     st_d = ST_FETCH;
        else                                 st_d = dir_rd_q ? ST_RD : ST_GET;
      end
      ST_FETCH: if (mem_ready_i && idx_last) st_d = ST_CHECK;
      ST_RD:    if (mem_ready_i)  st_d = ST_PUSH;
      ST_PUSH:  if (dev_rready_i) st_d = ST_CHECK;
      ST_GET:   if (dev_wvalid_i) st_d = ST_WR;
      ST_WR:    if (mem_ready_i)  st_d = ST_CHECK;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cur_q    <= '0;
      lim_q    <= '0;
      moved_q  <= '0;
      rem_q    <= '0;
      dir_rd_q <= 1'b0;
      idx_q    <= '0;
      buf_q    <= '0;
    end else begin
      st_q <= st_d;
      if (start) begin
        cur_q    <= start_i;
        lim_q    <= count_i;
        moved_q  <= '0;
        rem_q    <= dev_len_i;
        dir_rd_q <= write_i;
        idx_q    <= '0;
      end
      if (cap_o) idx_q <= idx_last ? '0 : idx_q + 1'b1;
      if (st_q == ST_RD && mem_ready_i)  buf_q <= mem_rdata_i;
      if (st_q == ST_GET && dev_wvalid_i) buf_q <= dev_wdata_i;
      if (advance) begin
        cur_q   <= cur_q + 1'b1;
        moved_q <= moved_q + 1'b1;
        rem_q   <= rem_q - 1'b1;
      end
    end
  end

  // R8
  reject_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_reject_o |=> st_q == ST_IDLE);
  // R9
  idle_norun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_IDLE && !run_i |=> st_q == ST_IDLE);
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R12
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o));
  // R6
  dev_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_rvalid_o && !dev_rready_i |=> dev_rvalid_o && $stable(dev_rdata_o));
endmodule

// File: rtl/pt_dma.sv
module pt_dma #(
  parameter int AW          = 32,
  parameter int LW          = 16,
  parameter int PAGE_BITS   = 12,
  parameter int ENTRY_BYTES = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          big_endian_i,
  input  logic          reg_wr_i,
  input  logic [5:0]    reg_addr_i,
  input  logic [AW-1:0] reg_wdata_i,
  output logic [AW-1:0] reg_rdata_o,
  input  logic          dev_req_i,
  input  logic          dev_to_mem_i,
  input  logic [LW-1:0] dev_len_i,
  output logic          dev_reject_o,
  output logic          done_o,
  input  logic [7:0]    dev_wdata_i,
  input  logic          dev_wvalid_i,
  output logic          dev_wready_o,
  output logic [7:0]    dev_rdata_o,
  output logic          dev_rvalid_o,
  input  logic          dev_rready_i,
  output logic          mem_valid_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  input  logic          mem_ready_i,
  input  logic [7:0]    mem_rdata_i
);
  localparam int IDX_W = $clog2(AW / 8);

  logic             run, wr_dir, clr_count, inval, cap, hit;
  logic [AW-1:0]    count, start, tbase, cur, paddr;
  logic [IDX_W-1:0] idx;

  pt_dma_regs #(.DW(AW)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .clr_count_i(clr_count),
    .run_o(run), .write_o(wr_dir), .count_o(count), .start_o(start), .tbase_o(tbase)
  );

  pt_dma_xlate #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_xlate (
    .clk_i, .rst_ni,
    .inval_i(inval), .cap_i(cap), .idx_i(idx), .byte_i(mem_rdata_i),
    .big_endian_i, .laddr_i(cur), .hit_o(hit), .paddr_o(paddr)
  );

  pt_dma_ctrl #(.AW(AW), .LW(LW), .PAGE_BITS(PAGE_BITS), .ENTRY_BYTES(ENTRY_BYTES)) u_ctrl (
    .clk_i, .rst_ni,
    .run_i(run), .write_i(wr_dir), .count_i(count), .start_i(start), .tbase_i(tbase),
    .dev_req_i, .dev_to_mem_i, .dev_len_i, .dev_reject_o, .done_o,
    .dev_wdata_i, .dev_wvalid_i, .dev_wready_o,
    .dev_rdata_o, .dev_rvalid_o, .dev_rready_i,
    .mem_valid_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ready_i, .mem_rdata_i,
    .inval_o(inval), .cap_o(cap), .idx_o(idx), .cur_o(cur), .hit_i(hit), .paddr_i(paddr)
  );

  assign clr_count = done_o;
endmodule

// File: tb/tb_pt_dma.sv
`timescale 1ns/1ps
module tb_pt_dma;
  logic        clk_i = 1'b0, rst_ni = 1'b0, big_endian_i = 1'b1;
  logic        reg_wr_i = 1'b0;
  logic [5:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic        dev_req_i = 1'b0, dev_to_mem_i = 1'b0;
  logic [15:0] dev_len_i = '0;
  logic        dev_reject_o, done_o;
  logic [7:0]  dev_wdata_i = '0;
  logic        dev_wvalid_i = 1'b0, dev_wready_o;
  logic [7:0]  dev_rdata_o;
  logic        dev_rvalid_o, dev_rready_i = 1'b0;
  logic        mem_valid_o, mem_we_o;
  logic [31:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic        mem_ready_i = 1'b0;
  logic [7:0]  mem_rdata_i = '0;

  pt_dma dut (.*);

  always #2 clk_i = ~clk_i;

  typedef struct {
    logic        we;
    logic [31:0] a;
    logic [7:0]  d;
    string       req;
  } beat_t;

  localparam logic [31:0] TBASE = 32'h0001_0000;

  logic [7:0]  mem_m [int unsigned];
  beat_t       exp_q[$];
  logic [7:0]  exp_dev_q[$];
  logic [7:0]  src_q[$];
  int unsigned cyc = 0;
  int n_vec = 0, n_err = 0, done_seen = 0;

  function automatic logic [7:0] rd(input logic [31:0] a);
    return mem_m.exists(a) ? mem_m[a] : (a[7:0] ^ a[15:8] ^ 8'h5A);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // cycle-by-cycle comparison of both interfaces against the queued model
  always @(negedge clk_i) begin
    cyc++;
    if (cyc == 150000) begin
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
    mem_ready_i = (cyc % 3) != 1;
    if (mem_valid_o && mem_ready_i) begin
      if (exp_q.size() == 0) chk(1'b0, "R12", "unexpected memory beat", mem_addr_o, 32'h0);
      else begin
        beat_t e;
        e = exp_q.pop_front();
        chk(mem_we_o == e.we && mem_addr_o == e.a && (!e.we || mem_wdata_o == e.d),
            e.req, "memory beat addr", mem_addr_o, e.a);
      end
      if (mem_we_o) mem_m[mem_addr_o] = mem_wdata_o;
      else mem_rdata_i = rd(mem_addr_o);
    end
    dev_rready_i = (cyc % 4) != 2;
    if (dev_rvalid_o && dev_rready_i) begin
      if (exp_dev_q.size() == 0) chk(1'b0, "R6", "unexpected device byte", dev_rdata_o, 0);
      else begin
        logic [7:0] eb;
        eb = exp_dev_q.pop_front();
        chk(dev_rdata_o == eb, "R6", "device byte", dev_rdata_o, eb);
      end
    end
    dev_wvalid_i = src_q.size() > 0 && (cyc % 5) != 3;
    dev_wdata_i  = src_q.size() > 0 ? src_q[0] : 8'h00;
    if (dev_wvalid_i && dev_wready_o) void'(src_q.pop_front());
    if (done_o) done_seen++;
  end

  task automatic reg_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic put_entry(input int page, input logic [31:0] v, input bit be);
    for (int i = 0; i < 4; i++)
      mem_m[TBASE + page * 8 + i] = be ? v[8*(3-i) +: 8] : v[8*i +: 8];
  endtask

  // pulse a request; returns the reject level seen in that cycle
  task automatic pulse_req(input bit to_mem, input logic [15:0] len, output bit rej);
    @(negedge clk_i);
    dev_req_i = 1'b1; dev_to_mem_i = to_mem; dev_len_i = len;
    #1 rej = dev_reject_o;
    @(negedge clk_i);
    dev_req_i = 1'b0;
  endtask

  task automatic xfer(input logic [31:0] addr, input logic [31:0] cnt, input int len,
                      input bit rd_dir, input bit be, input string tag);
    int n, d0;
    bit rej;
    logic [31:0] rb;
    big_endian_i = be;
    reg_wr(6'h18, addr);
    reg_wr(6'h10, cnt);
    reg_wr(6'h08, {30'b0, rd_dir, 1'b1});
    n = (cnt < len) ? int'(cnt) : len;
    for (int k = 0; k < n; k++) begin
      logic [31:0] la, ta, ent, pa;
      beat_t b;
      la = addr + k;
      ta = TBASE + ((la >> 12) << 3);
      if (k == 0 || la[11:0] == 12'h000)
        for (int i = 0; i < 4; i++) begin
          b.we = 1'b0; b.a = ta + i; b.d = 8'h00; b.req = "R3 R11 fetch";
          exp_q.push_back(b);
        end
      ent = be ? {rd(ta), rd(ta+1), rd(ta+2), rd(ta+3)}
               : {rd(ta+3), rd(ta+2), rd(ta+1), rd(ta)};
      pa = {ent[31:12], la[11:0]};
      if (rd_dir) begin
        b.we = 1'b0; b.a = pa; b.d = 8'h00; b.req = {tag, " R4 R6 read"};
        exp_dev_q.push_back(rd(pa));
      end else begin
        b.we = 1'b1; b.a = pa; b.d = 8'hC0 + 8'(k); b.req = {tag, " R4 R7 write"};
        src_q.push_back(8'hC0 + 8'(k));
      end
      exp_q.push_back(b);
    end
    d0 = done_seen;
    pulse_req(!rd_dir, 16'(len), rej);
    chk(rej == 1'b0, "R8", "reject on matching direction", 32'(rej), 0);
    for (int i = 0; i < 4000 && done_seen == d0; i++) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
    // R10 single completion, all beats used, count cleared
    chk(done_seen == d0 + 1, "R10", "completion pulses", done_seen - d0, 1);
    chk(exp_q.size() == 0, "R10", "memory beats left", exp_q.size(), 0);
    chk(exp_dev_q.size() == 0, "R6", "device bytes left", exp_dev_q.size(), 0);
    reg_rd(6'h10, rb);
    chk(rb == 0, "R10", "count after transfer", rb, 0);
    src_q.delete();
  endtask

  initial begin
    logic [31:0] rb;
    bit rej;
    int d0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(!mem_valid_o && !dev_rvalid_o && !dev_wready_o && !done_o && !dev_reject_o,
        "R1", "idle outputs", {mem_valid_o, dev_rvalid_o, dev_wready_o, done_o}, 0);
    rst_ni = 1'b1;
    for (int i = 0; i < 6; i++) begin
      reg_rd(6'(i * 8), rb);
      chk(rb == 0, "R1", "register after reset", rb, 0);
    end

    // R2 register readback and unused offset
    reg_wr(6'h00, 32'hA5A5_0003);
    reg_wr(6'h28, 32'h0000_1234);
    reg_wr(6'h20, TBASE);
    reg_wr(6'h30, 32'hFFFF_FFFF);
    reg_rd(6'h00, rb); chk(rb == 32'hA5A5_0003, "R2", "mode readback", rb, 32'hA5A5_0003);
    reg_rd(6'h28, rb); chk(rb == 32'h0000_1234, "R2", "limit readback", rb, 32'h0000_1234);
    reg_rd(6'h20, rb); chk(rb == TBASE, "R2", "base readback", rb, TBASE);
    reg_rd(6'h30, rb); chk(rb == 0, "R2", "unused offset", rb, 0);

    put_entry(1, 32'h0040_2ABC, 1'b1);
    put_entry(2, 32'h0077_5123, 1'b1);
    put_entry(3, 32'h0033_3FFF, 1'b1);
    put_entry(4, 32'h0044_4001, 1'b1);
    put_entry(5, 32'h0088_1FFF, 1'b0);
    put_entry(6, 32'h0099_0001, 1'b0);

    // memory to device across a page, count below device length (R11, R10)
    xfer(32'h0000_1FFC, 32'd8, 20, 1'b1, 1'b1, "T1");
    // little-endian entries (R5)
    xfer(32'h0000_5FFE, 32'd4, 4, 1'b1, 1'b0, "R5");
    // device to memory across a page, device length below count (R7, R10)
    xfer(32'h0000_3FFE, 32'd10, 5, 1'b0, 1'b1, "T3");
    // zero count (R10)
    xfer(32'h0000_1000, 32'd0, 6, 1'b1, 1'b1, "T6");

    // direction mismatch (R8)
    big_endian_i = 1'b1;
    reg_wr(6'h10, 32'd7);
    reg_wr(6'h08, 32'h3);
    d0 = done_seen;
    pulse_req(1'b1, 16'd4, rej);
    chk(rej == 1'b1, "R8", "reject pulse", 32'(rej), 1);
    repeat (20) @(negedge clk_i);
    chk(done_seen == d0, "R8", "no completion", done_seen - d0, 0);
    reg_rd(6'h10, rb); chk(rb == 32'd7, "R8", "count kept", rb, 7);

    // RUN clear (R9)
    reg_wr(6'h08, 32'h2);
    pulse_req(1'b0, 16'd4, rej);
    chk(rej == 1'b0, "R9", "no reject", 32'(rej), 0);
    repeat (20) @(negedge clk_i);
    chk(done_seen == d0, "R9", "no completion", done_seen - d0, 0);
    chk(!mem_valid_o && !dev_rvalid_o, "R9", "engine idle", {mem_valid_o, dev_rvalid_o}, 0);
    reg_rd(6'h10, rb); chk(rb == 32'd7, "R9", "count kept", rb, 7);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule